// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block is a single-port on-chip memory with registered inputs. A client may present one command per clock cycle. A command is either a read or a write. For a write, the client supplies the data one cycle after the command. A separate register keeps the write's address until that data has been captured. Because of this register, the address bus is free again on the very next cycle. Reads and writes can therefore follow each other in any order at the full clock rate, with no turnaround gap.

Each read returns a result after a fixed latency, which is set by a parameter. A read of a location whose write is still waiting to commit takes its data from a bypass path, so every read sees every write issued before it.

Top module: `latewr_sram`

## Requirements
- R1: `cmd_valid`, `cmd_write` and `cmd_addr` are sampled on the rising clock edge that ends the cycle in which they are driven. A command occupies exactly that one cycle.
- R2: For a write command in cycle t, the value on `wr_data` in cycle t+1 is the value stored. The value on `wr_data` in cycle t itself is not used for that write.
- R3: The address of a write is held internally until its data is captured. A different address presented in cycle t+1 does not redirect the write.
- R4: Write commands issued in consecutive cycles, each with its own data one cycle later, all land at their own addresses.
- R5: A read command in cycle t raises `rd_valid` in cycle t+1+RD_LAT, with RD_LAT equal to 1 or 2. `rd_data` in that cycle carries the result. `rd_valid` is high in no other cycle.
- R6: A read issued in the cycle right after a write to the same address returns that write's data. If two writes to the address precede the read, the later write's data is returned.
- R7: A read issued two or more cycles after a write returns the written data. A read issued in the cycle before a write to the same address returns the old contents.
- R8: While `rst_n` is low, `rd_valid` is low and no write is pending. A write whose data cycle falls inside reset leaves the array unchanged. The array changes only in a cycle that follows a captured write.
- R9: `wr_data` is ignored in any cycle that does not follow a write command, namely after idle cycles (`cmd_valid` low) and after read cycles.
- R10: Reads and writes may alternate every cycle with no idle cycle between them, and every read stays correct.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read (when `cmd_valid`) |
| cmd_addr | input | ADDR_W | Command address |
| wr_data | input | DATA_W | Write data, driven one cycle after its write command |
| rd_valid | output | 1 | Read result present this cycle |
| rd_data | output | DATA_W | Read result |

## Verification
The assertions check these properties on every cycle:
- A pending write only ever follows a captured write command.
- The array holds still in any cycle without a pending write.
- A read that hits the pending write's address takes the pending data into its first result stage.
- `rd_valid` is always preceded, RD_LAT+1 cycles earlier, by a read command.

The data-ordering behaviours can only be shown by the bench's scenarios, because they depend on command history. These are:
- Write streams at full rate.
- Read-after-write at distance one and distance two.
- Read-before-write.
- Garbage on `wr_data` during idle and read cycles.
- A write whose data cycle is cut off by reset.

// File: rtl/latewr_pkg.sv
package latewr_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

endpackage

// File: rtl/latewr_cmd_stage.sv
module latewr_cmd_stage
  import latewr_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  output op_e               s_op,
  output logic [ADDR_W-1:0] s_addr
);

  op_e               op_d;
  logic              addr_en;

  always_comb begin
    op_d    = OP_IDLE;
    addr_en = cmd_valid;
    if (cmd_valid) begin
      op_d = cmd_write ? OP_WRITE : OP_READ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_op <= OP_IDLE;
    end else begin
      s_op <= op_d;
    end
  end

  always_ff @(posedge clk) begin
    if (addr_en) begin
      s_addr <= cmd_addr;
    end
  end

endmodule

// File: rtl/latewr_wr_hold.sv
module latewr_wr_hold
  import latewr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               s_op,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pend_v,
  output logic [ADDR_W-1:0] pend_addr,
  output logic [DATA_W-1:0] pend_data
);

  logic capture;
  logic pend_v_d;

  always_comb begin
    capture  = (s_op == OP_WRITE);
    pend_v_d = capture;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v <= 1'b0;
    end else begin
      pend_v <= pend_v_d;
    end
  end

  always_ff @(posedge clk) begin
    if (capture) begin
      pend_addr <= s_addr;
      pend_data <= wr_data;
    end
  end

  // R3: a pending write exists only if the command stage held a write
  p_pend_from_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pend_v |-> $past(s_op == OP_WRITE));

endmodule

// File: rtl/latewr_array.sv
module latewr_array #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0][DATA_W-1:0] mem;

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_comb begin
    rdata = mem[raddr];
  end

  // R8: contents move only on a cycle that carries a pending write
  p_no_commit_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mem));

endmodule

// File: rtl/latewr_rd_pipe.sv
module latewr_rd_pipe
  import latewr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int RD_LAT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               s_op,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic              pend_v,
  input  logic [ADDR_W-1:0] pend_addr,
  input  logic [DATA_W-1:0] pend_data,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  localparam int LAST = RD_LAT - 1;

  logic [RD_LAT-1:0] v_d, v_q;
  logic [DATA_W-1:0] d_d [RD_LAT];
  logic [DATA_W-1:0] d_q [RD_LAT];
  logic              hit;

  always_comb begin
    hit    = pend_v && (pend_addr == s_addr);
    v_d[0] = (s_op == OP_READ);
    d_d[0] = hit ? pend_data : arr_rdata;
  end

  for (genvar k = 1; k < RD_LAT; k++) begin : g_extra
    always_comb begin
      v_d[k] = v_q[k-1];
      d_d[k] = d_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
    end else begin
      v_q <= v_d;
    end
  end

  for (genvar k = 0; k < RD_LAT; k++) begin : g_data
    always_ff @(posedge clk) begin
      if (v_d[k]) begin
        d_q[k] <= d_d[k];
      end
    end
  end

  assign rd_valid = v_q[LAST];
  assign rd_data  = d_q[LAST];

  // R6: a read matching the uncommitted write picks up the held data
  p_fwd_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (s_op == OP_READ && pend_v && pend_addr == s_addr) |=>
      (d_q[0] == $past(pend_data)));

endmodule

// File: rtl/latewr_sram.sv
module latewr_sram
  import latewr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int RD_LAT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  op_e               s_op;
  logic [ADDR_W-1:0] s_addr;
  logic              pend_v;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_data;
  logic [DATA_W-1:0] arr_rdata;

  latewr_cmd_stage #(.ADDR_W(ADDR_W)) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_write (cmd_write),
    .cmd_addr  (cmd_addr),
    .s_op      (s_op),
    .s_addr    (s_addr)
  );

  latewr_wr_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_op      (s_op),
    .s_addr    (s_addr),
    .wr_data   (wr_data),
    .pend_v    (pend_v),
    .pend_addr (pend_addr),
    .pend_data (pend_data)
  );

  latewr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (pend_v),
    .waddr (pend_addr),
    .wdata (pend_data),
    .raddr (s_addr),
    .rdata (arr_rdata)
  );

  latewr_rd_pipe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_LAT(RD_LAT)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_op      (s_op),
    .s_addr    (s_addr),
    .pend_v    (pend_v),
    .pend_addr (pend_addr),
    .pend_data (pend_data),
    .arr_rdata (arr_rdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  // R5: every result is the product of a read issued RD_LAT+1 cycles earlier
  p_rd_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(cmd_valid && !cmd_write, RD_LAT + 1));

endmodule

// File: tb/test_latewr_sram.sv
`timescale 1ns/1ps
module test_latewr_sram;

  localparam int AW  = 4;
  localparam int DW  = 8;
  localparam int LAT = 1;
  localparam int DEP = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid;
  logic          cmd_write;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] wr_data;
  logic          rd_valid;
  logic [DW-1:0] rd_data;

  always #2 clk = ~clk;

  latewr_sram #(.ADDR_W(AW), .DATA_W(DW), .RD_LAT(LAT)) i_latewr_sram (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_write (cmd_write),
    .cmd_addr  (cmd_addr),
    .wr_data   (wr_data),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 0;

  logic [DW-1:0] ref_mem [DEP];
  logic [DW-1:0] next_wd;
  logic [DW-1:0] exp_q [$];
  string         tag_q [$];
  int            iss_q [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: one command per call; data of a previous write follows in this cycle
  task automatic op(input bit v, input bit w, input int a, input int d, input string tag);
    @(negedge clk);
    cmd_valid = v;
    cmd_write = w;
    cmd_addr  = AW'(a);
    wr_data   = next_wd;
    if (v && w) begin
      next_wd = DW'(d);
      ref_mem[a] = DW'(d);
    end else begin
      next_wd = DW'($urandom);
      if (v) begin
        exp_q.push_back(ref_mem[a]);
        tag_q.push_back(tag);
        iss_q.push_back(cyc);
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) op(0, 0, 0, 0, "");
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        chk(0, "R5 unexpected rd_valid", 1, 0);
      end else begin
        logic [DW-1:0] e;
        string t;
        int ic;
        e  = exp_q.pop_front();
        t  = tag_q.pop_front();
        ic = iss_q.pop_front();
        chk(rd_data == e, t, rd_data, e);
        chk(cyc == ic + 1 + LAT, "R5 latency", cyc, ic + 1 + LAT);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cmd_valid = 0; cmd_write = 0; cmd_addr = '0; wr_data = '0;
    next_wd = '0;
    for (int i = 0; i < DEP; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(rd_valid == 1'b0, "R8 reset rd_valid", rd_valid, 0);
    rst_n = 1'b1;

    // R4 R3 R2: full-rate write stream, then read back
    for (int i = 0; i < DEP; i++) op(1, 1, i, 8'h10 + i * 7, "");
    for (int i = 0; i < DEP; i++) op(1, 0, i, 0, "R4 R3 R2 R1 stream readback");
    idle(4);

    // R6: read right after write, and after two writes to the same address
    op(1, 1, 3, 8'hA5, "");
    op(1, 0, 3, 0, "R6 forward one");
    op(1, 1, 7, 8'h11, "");
    op(1, 1, 7, 8'h22, "");
    op(1, 0, 7, 0, "R6 forward newest");
    idle(3);

    // R7: read-before-write sees old, distance-two sees new
    op(1, 0, 9, 0, "R7 read before write");
    op(1, 1, 9, 8'h5A, "");
    op(0, 0, 0, 0, "");
    op(1, 0, 9, 0, "R7 distance two");
    idle(3);

    // R9: garbage on wr_data during idle and read cycles
    idle(5);
    op(1, 0, 2, 0, "R9 read amid garbage");
    op(1, 0, 4, 0, "R9 read amid garbage");
    idle(3);
    for (int i = 0; i < DEP; i++) op(1, 0, i, 0, "R9 array untouched");
    idle(3);

    // R10: alternate writes and reads every cycle
    for (int i = 0; i < 20; i++) begin
      op(1, 1, i % DEP, 8'hC0 + i, "");
      op(1, 0, (i * 5) % DEP, 0, "R10 interleave");
    end
    idle(4);

    // R8: write whose data cycle is cut by reset leaves contents unchanged
    op(1, 1, 5, 8'h3C, "");
    idle(4);
    @(negedge clk);
    cmd_valid = 1; cmd_write = 1; cmd_addr = 4'd5; wr_data = next_wd;
    @(negedge clk);
    cmd_valid = 0; wr_data = 8'hC3; rst_n = 1'b0;
    @(negedge clk);
    chk(rd_valid == 1'b0, "R8 rd_valid in reset", rd_valid, 0);
    rst_n = 1'b1;
    next_wd = '0;
    op(1, 0, 5, 0, "R8 aborted write");
    idle(5);

    chk(exp_q.size() == 0, "R5 all reads answered", exp_q.size(), 0);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule